// File: doc/BRIEF.md
# Accumulator Bitfield Extractor

This block pulls a bitfield of 1 to 32 bits out of a 64-bit accumulator and returns it right-aligned and zero-extended in a 32-bit result. The field is located by a 6-bit position register that names the field's most significant bit. The field's lower bits lie below that bit. The length comes either from a 5-bit immediate or from the low bits of a register operand. In both cases the length is the code plus one.

One operation is issued per cycle with a valid strobe. A 2-bit operation code selects the operation. A plain extract leaves the position alone. An auto-decrement extract lowers the position by the extracted length, so a run of extracts unpacks the accumulator field by field from the top down. A set operation loads the position. A request whose field would run below bit 0 raises an error flag, returns zero and leaves the position unchanged. A flag that is high while the position is 32 or more is provided as a branch condition.

Top module: `acc_field_extract`

## Requirements
- R1: While rst_ni is low and after it is released, pos_o is 0, field_o is 0, field_valid_o is 0, err_o is 0 and pos_ge32_o is 0.
- R2: A valid strobe with op_i = 2 (set) loads pos_wdata_i into pos_o on the next cycle. It leaves field_o and err_o unchanged and raises no field_valid_o.
- R3: With len_sel_i = 0 the length is len_imm_i + 1. With len_sel_i = 1 the length is len_reg_i[4:0] + 1, and len_reg_i[31:5] have no effect.
- R4: On the cycle after a valid extract (op_i = 0 or 1), field_o holds accumulator bits pos down to pos-len+1, with bit pos-len+1 placed at field_o[0] and zeros above the field. field_valid_o is high for that one cycle.
- R5: A 32-bit length returns all 32 accumulator bits ending at pos. A 1-bit length returns the single bit at pos.
- R6: A plain extract (op_i = 0) never changes pos_o.
- R7: An auto-decrement extract (op_i = 1) without error sets pos_o to (pos - len) modulo 64. Extracting exactly down to bit 0 therefore leaves pos_o at 63.
- R8: An extract with pos+1 < len sets err_o, returns field_o = 0 and leaves pos_o unchanged, in either extract mode. The next extract without error clears err_o.
- R9: pos_ge32_o is high exactly while pos_o is 32 or more.
- R10: op_i = 3 with a valid strobe changes nothing: pos_o, field_o and err_o keep their values and field_valid_o stays low.
- R11: Without valid_i, outputs and position keep their values, field_valid_o is low, and the accumulator may change freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | 0 extract, 1 extract with decrement, 2 set position, 3 no operation |
| len_sel_i | input | 1 | Length source: 0 immediate, 1 register |
| len_imm_i | input | 5 | Immediate length code (length minus one) |
| len_reg_i | input | 32 | Register operand; bits 4:0 give the length code |
| pos_wdata_i | input | 6 | Position value for the set operation |
| acc_i | input | 64 | Accumulator value |
| field_o | output | 32 | Extracted field, zero-extended |
| field_valid_o | output | 1 | One-cycle pulse after each extract |
| err_o | output | 1 | Last extract ran below bit 0 |
| pos_o | output | 6 | Current position (field top bit) |
| pos_ge32_o | output | 1 | Position is 32 or more |

## Verification
The accumulator is a pattern with distinct nibbles, so a result tells apart fields that start one bit off or are one bit too long or too short. Extracts at the top bit, in the middle, at full 32-bit width and at a single bit separate off-by-one errors in the shift from errors in the mask. A four-step decrement run across all 64 bits shows the position steps by the length and wraps to 63 after the last field, and the branch flag is checked at each step. Register-sourced lengths with junk in the upper bits, error cases at both extract modes, the reserved operation and accumulator changes without a strobe show what must stay untouched.

// File: rtl/afe_pkg.sv
package afe_pkg;
  typedef enum logic [1:0] {
    OP_EXT     = 2'd0,
    OP_EXT_DEC = 2'd1,
    OP_SET_POS = 2'd2,
    OP_NOP     = 2'd3
  } op_e;
endpackage

// File: rtl/afe_len_sel.sv
module afe_len_sel #(
  parameter int OUT_W = 32,
  localparam int LEN_W = $clog2(OUT_W)
) (
  input  logic             sel_i,
  input  logic [LEN_W-1:0] imm_i,
  input  logic [OUT_W-1:0] reg_i,
  output logic [LEN_W:0]   len_o
);
  logic [LEN_W-1:0] code;
  assign code  = sel_i ? reg_i[LEN_W-1:0] : imm_i;
  assign len_o = {1'b0, code} + (LEN_W+1)'(1);
endmodule

// File: rtl/afe_field_shift.sv
module afe_field_shift #(
  parameter int ACC_W = 64,
  parameter int OUT_W = 32,
  localparam int POS_W = $clog2(ACC_W),
  localparam int LEN_W = $clog2(OUT_W)
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [LEN_W:0]   len_i,
  output logic [OUT_W-1:0] field_o,
  output logic             fits_o
);
  logic [POS_W:0]   top_p1;
  logic [POS_W:0]   lo;
  logic [ACC_W-1:0] shifted;
  logic [OUT_W-1:0] mask;

  assign top_p1  = {1'b0, pos_i} + (POS_W+1)'(1);
  assign fits_o  = top_p1 >= (POS_W+1)'(len_i);
  assign lo      = top_p1 - (POS_W+1)'(len_i);
  assign shifted = acc_i >> lo;

  for (genvar i = 0; i < OUT_W; i++) begin : g_mask
    assign mask[i] = (LEN_W+1)'(i) < len_i;
  end

  assign field_o = fits_o ? (shifted[OUT_W-1:0] & mask) : '0;

  always_comb begin
    if (!fits_o) a_r8_zero_on_err: assert (field_o == '0);
  end
endmodule

// File: rtl/afe_pos_reg.sv
module afe_pos_reg #(
  parameter int ACC_W = 64,
  parameter int THR   = 32,
  localparam int POS_W = $clog2(ACC_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic [POS_W-1:0] set_val_i,
  input  logic             dec_en_i,
  input  logic [POS_W-1:0] dec_len_i,
  output logic [POS_W-1:0] pos_o,
  output logic             ge_o
);
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pos_q <= '0;
    else if (set_en_i) pos_q <= set_val_i;
    else if (dec_en_i) pos_q <= pos_q - dec_len_i;
  end

  assign pos_o = pos_q;
  assign ge_o  = pos_q >= POS_W'(THR);

  a_r2_set_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> pos_q == $past(set_val_i));
  a_r7_dec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_en_i && !set_en_i |=> pos_q == POS_W'($past(pos_q) - $past(dec_len_i)));
  a_r9_flag_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i && set_val_i >= POS_W'(THR) |=> ge_o);
  a_r9_flag_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i && set_val_i < POS_W'(THR) |=> !ge_o);
endmodule

// File: rtl/acc_field_extract.sv
module acc_field_extract #(
  parameter int ACC_W = 64,
  parameter int OUT_W = 32,
  localparam int POS_W = $clog2(ACC_W),
  localparam int LEN_W = $clog2(OUT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic             len_sel_i,
  input  logic [LEN_W-1:0] len_imm_i,
  input  logic [OUT_W-1:0] len_reg_i,
  input  logic [POS_W-1:0] pos_wdata_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [OUT_W-1:0] field_o,
  output logic             field_valid_o,
  output logic             err_o,
  output logic [POS_W-1:0] pos_o,
  output logic             pos_ge32_o
);
  import afe_pkg::*;

  op_e              op;
  logic [LEN_W:0]   len;
  logic [OUT_W-1:0] field_raw;
  logic             fits;
  logic             is_ext, set_en, dec_en;
  logic [OUT_W-1:0] field_q;
  logic             fv_q, err_q;

  assign op     = op_e'(op_i);
  assign is_ext = valid_i && (op == OP_EXT || op == OP_EXT_DEC);
  assign set_en = valid_i && op == OP_SET_POS;
  assign dec_en = valid_i && op == OP_EXT_DEC && fits;

  afe_len_sel #(.OUT_W(OUT_W)) u_len (
    .sel_i (len_sel_i),
    .imm_i (len_imm_i),
    .reg_i (len_reg_i),
    .len_o (len)
  );

  afe_field_shift #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_shift (
    .acc_i   (acc_i),
    .pos_i   (pos_o),
    .len_i   (len),
    .field_o (field_raw),
    .fits_o  (fits)
  );

  afe_pos_reg #(.ACC_W(ACC_W), .THR(OUT_W)) u_pos (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_en_i  (set_en),
    .set_val_i (pos_wdata_i),
    .dec_en_i  (dec_en),
    .dec_len_i (POS_W'(len)),
    .pos_o     (pos_o),
    .ge_o      (pos_ge32_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= '0;
      fv_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      fv_q <= is_ext;
      if (is_ext) begin
        field_q <= field_raw;
        err_q   <= !fits;
      end
    end
  end

  assign field_o       = field_q;
  assign field_valid_o = fv_q;
  assign err_o         = err_q;

  a_r8_err_field_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> field_o == '0);
  a_r8_err_pos_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ext && !fits |=> $stable(pos_o) && err_o);
  a_r6_plain_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op == OP_EXT |=> $stable(pos_o));
  a_r10_nop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op == OP_NOP |=> $stable(pos_o) && $stable(field_o) && !field_valid_o);
  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pos_o) && $stable(field_o) && $stable(err_o) && !field_valid_o);
  a_r4_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ext |=> field_valid_o);
endmodule

// File: tb/sim_acc_field_extract.sv
module sim_acc_field_extract;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        len_sel = 1'b0;
  logic [4:0]  len_imm = '0;
  logic [31:0] len_reg = '0;
  logic [5:0]  pos_wd = '0;
  logic [63:0] acc = '0;
  logic [31:0] field;
  logic        fv, err, ge;
  logic [5:0]  pos;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [5:0] mpos = '0;

  localparam logic [63:0] PAT = 64'h0123_4567_89AB_CDEF;

  always #4 clk = ~clk;

  acc_field_extract u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .len_sel_i(len_sel), .len_imm_i(len_imm), .len_reg_i(len_reg),
    .pos_wdata_i(pos_wd), .acc_i(acc), .field_o(field),
    .field_valid_o(fv), .err_o(err), .pos_o(pos), .pos_ge32_o(ge)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl(logic [63:0] a, int p, int l);
    logic [31:0] r = '0;
    if (p + 1 < l) return '0;
    for (int i = 0; i < l; i++) r[i] = a[p - l + 1 + i];
    return r;
  endfunction

  task automatic issue(logic [1:0] o, logic s, logic [4:0] im, logic [31:0] rg,
                       logic [5:0] wd, logic [63:0] a);
    @(negedge clk);
    op = o; len_sel = s; len_imm = im; len_reg = rg; pos_wd = wd; acc = a;
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic set_pos(logic [5:0] p, string req);
    issue(2'd2, 1'b0, 5'd0, 32'd0, p, PAT);
    mpos = p;
    chk(req, "pos after set", pos, p);
    chk(req, "no pulse on set", fv, 0);
  endtask

  task automatic t_reset;
    chk("R1", "pos", pos, 0);
    chk("R1", "field", field, 0);
    chk("R1", "valid", fv, 0);
    chk("R1", "err", err, 0);
    chk("R1", "ge32", ge, 0);
  endtask

  task automatic t_plain;
    set_pos(6'd63, "R2");
    chk("R9", "ge32 at 63", ge, 1);
    issue(2'd0, 1'b0, 5'd7, 32'd0, 6'd0, PAT);
    chk("R4", "top byte", field, mdl(PAT, 63, 8));
    chk("R4", "pulse", fv, 1);
    chk("R6", "pos held", pos, 63);
    @(negedge clk);
    chk("R4", "pulse one cycle", fv, 0);
    set_pos(6'd39, "R2");
    issue(2'd0, 1'b1, 5'd3, 32'hFFFF_FFE0 | 32'd15, 6'd0, PAT);
    chk("R3", "reg length 16 junk high", field, mdl(PAT, 39, 16));
    issue(2'd0, 1'b0, 5'd11, 32'h0000_001F, 6'd0, PAT);
    chk("R3", "imm length 12 ignores reg", field, mdl(PAT, 39, 12));
    chk("R6", "pos still 39", pos, 39);
  endtask

  task automatic t_edges;
    set_pos(6'd31, "R2");
    chk("R9", "ge32 at 31", ge, 0);
    issue(2'd0, 1'b0, 5'd31, 32'd0, 6'd0, PAT);
    chk("R5", "32 bits at 31", field, 32'h89AB_CDEF);
    set_pos(6'd63, "R2");
    issue(2'd0, 1'b0, 5'd31, 32'd0, 6'd0, PAT);
    chk("R5", "32 bits at 63", field, 32'h0123_4567);
    set_pos(6'd0, "R2");
    issue(2'd0, 1'b0, 5'd0, 32'd0, 6'd0, PAT);
    chk("R5", "bit 0", field, 1);
    set_pos(6'd57, "R2");
    issue(2'd0, 1'b0, 5'd0, 32'd0, 6'd0, PAT);
    chk("R5", "bit 57", field, mdl(PAT, 57, 1));
  endtask

  task automatic t_dec;
    logic [15:0] exp_f [4] = '{16'h0123, 16'h4567, 16'h89AB, 16'hCDEF};
    logic [5:0]  exp_p [4] = '{6'd47, 6'd31, 6'd15, 6'd63};
    set_pos(6'd63, "R2");
    for (int k = 0; k < 4; k++) begin
      issue(2'd1, 1'b1, 5'd0, 32'd15, 6'd0, PAT);
      chk("R7", "dec field", field, exp_f[k]);
      chk("R7", "dec pos", pos, exp_p[k]);
      chk("R9", "ge32 tracks", ge, exp_p[k] >= 32);
      chk("R8", "no err", err, 0);
    end
  endtask

  task automatic t_err;
    set_pos(6'd3, "R2");
    issue(2'd1, 1'b0, 5'd4, 32'd0, 6'd0, PAT);
    chk("R8", "err dec", err, 1);
    chk("R8", "field zero", field, 0);
    chk("R8", "pos held dec", pos, 3);
    chk("R8", "pulse on err", fv, 1);
    issue(2'd0, 1'b0, 5'd3, 32'd0, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R8", "exact fit clears err", err, 0);
    chk("R8", "exact fit field", field, 32'hF);
    issue(2'd0, 1'b1, 5'd0, 32'd31, 6'd0, PAT);
    chk("R8", "err plain", err, 1);
    chk("R8", "pos held plain", pos, 3);
    issue(2'd1, 1'b0, 5'd3, 32'd0, 6'd0, PAT);
    chk("R7", "dec to bit 0 wraps", pos, 63);
    chk("R7", "wrap field", field, mdl(PAT, 3, 4));
  endtask

  task automatic t_hold;
    logic [31:0] f0;
    set_pos(6'd40, "R2");
    issue(2'd0, 1'b0, 5'd9, 32'd0, 6'd0, PAT);
    f0 = field;
    issue(2'd3, 1'b0, 5'd0, 32'd0, 6'd5, ~PAT);
    chk("R10", "nop pos", pos, 40);
    chk("R10", "nop field", field, f0);
    chk("R10", "nop pulse", fv, 0);
    issue(2'd2, 1'b0, 5'd0, 32'd0, 6'd12, ~PAT);
    chk("R2", "set keeps field", field, f0);
    @(negedge clk);
    acc = ~PAT; op = 2'd1; len_imm = 5'd2;
    repeat (3) @(negedge clk);
    chk("R11", "idle pos", pos, 12);
    chk("R11", "idle field", field, f0);
    chk("R11", "idle pulse", fv, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_edges();
    t_dec();
    t_err();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule